// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block turns a pixel clock and five packed configuration words into display timing: horizontal and vertical sync, a data-enable window, raw pixel and line counters, a field flag for interlaced output, and a single-cycle interrupt on a chosen line. Geometry is held in minus-one form, with two 16-bit halves per word. The vertical total is given in half-lines, so an interlaced frame can hold an odd number of half-lines, split across two fields of unequal length.

Software writes the words and raises the enable input. The block copies all the words into shadow registers while it is disabled, and again only on the last pixel of a frame. A frame that is being scanned therefore always uses one consistent geometry. A start-delay field pushes the first active line further down, and the line interrupt follows that delay. A control bit marks the active area for replacement by a flat blue fill.

Top module: `video_timing_gen`

## Requirements
- R1: `cfgSize[31:16]` holds active width minus one and `cfgSize[15:0]` holds active height minus one. Within a field, `de` is high for exactly width × height pixel cycles.
- R2: `xPos` counts 0 to `cfgHoriz[31:16]` and then wraps. Horizontal sync is active while `xPos` < `cfgSync[31:16]`+1. The first active pixel is at `xPos` = `cfgHoriz[15:0]`+1, so the back porch is counted from the start of sync.
- R3: `cfgVert[31:16]` is the vertical total in half-lines, and a progressive field has that value divided by two lines. Vertical sync is active while `yPos` < `cfgSync[15:0]`+1. The first active line is `cfgVert[15:0]`+1 plus the start delay.
- R4: `cfgCtrl[0]` selects interlace. In interlaced mode `field` toggles at the end of every field. Field 0 has floor(total/2) lines and field 1 has ceil(total/2) lines. In progressive mode `field` stays 0.
- R5: `cfgCtrl[1]`=1 makes hsync active-high and 0 makes it active-low. `cfgCtrl[2]` sets vsync polarity the same way. The two bits are independent.
- R6: The start delay is read from `cfgCtrl[8:4]`, and any value above 30 is treated as 30.
- R7: `lineIrq` is a one-cycle pulse at `xPos`=0 of line start-delay+2, once per field.
- R8: When `cfgCtrl[12]` is 1, `blueFill` equals `de`. When it is 0, `blueFill` stays low.
- R9: While `enable` is low, `de`, `lineIrq` and `blueFill` are low and both syncs sit at their inactive levels, with no cycle of delay. From the next clock edge on, `xPos`, `yPos` and `field` are 0.
- R10: Configuration words changed while enabled take effect only after the last pixel of a frame. In interlaced mode that is the last pixel of field 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the timing; low holds the counters at zero |
| cfgSize | input | 32 | Active width-1 / height-1 |
| cfgHoriz | input | 32 | Horizontal total-1 / back porch-1 |
| cfgVert | input | 32 | Vertical total in half-lines / back porch-1 |
| cfgSync | input | 32 | Hsync width-1 / vsync width-1 |
| cfgCtrl | input | 32 | Interlace, polarities, start delay, blue fill |
| hsync | output | 1 | Horizontal sync at the programmed polarity |
| vsync | output | 1 | Vertical sync at the programmed polarity |
| de | output | 1 | Active-area data enable |
| blueFill | output | 1 | Replace pixel data with blue in the active area |
| xPos | output | 16 | Pixel counter within the line |
| yPos | output | 16 | Line counter within the field |
| field | output | 1 | Current field of an interlaced frame |
| lineIrq | output | 1 | Line-match interrupt pulse |

## Verification
The assertions check, on every cycle, that the outputs stay quiet while disabled and that the counters collapse to zero one edge later. They also check that `xPos` only steps by one or wraps, that the field changes only at the origin, and that the interrupt is a single pulse at the start of a line that never coincides with a stray blue fill. Only the bench scenarios can show the actual geometry. That covers window placement against the back porch and delay, the half-line split between fields, the clamp on the delay, polarity choice, and the frame-boundary moment at which a rewritten configuration is picked up. The bench checks these against a cycle model built from the requirements.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int ILACE_BIT = 0;
  localparam int HPOL_BIT  = 1;
  localparam int VPOL_BIT  = 2;
  localparam int BLUE_BIT  = 12;

  // Strobes from the scan control to the timing datapath
  typedef struct packed {
    logic loadCfg;    // copy configuration words into the shadow set
    logic lineStart;  // counters sit on pixel 0 of a line while running
  } vtgStrobe_t;
endpackage

// File: rtl/vtg_control.sv
module vtg_control
  import vtg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [CNT_W-1:0] hLast,
  input  logic [CNT_W-1:0] vLast,
  input  logic             interlace,
  output vtgStrobe_t       strb,
  output logic [CNT_W-1:0] hCount,
  output logic [CNT_W-1:0] vLine,
  output logic             field
);
  logic atLineEnd;
  logic atFieldEnd;
  logic atFrameEnd;

  assign atLineEnd  = (hCount == hLast);
  assign atFieldEnd = atLineEnd && (vLine == vLast);
  assign atFrameEnd = atFieldEnd && (field || !interlace);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCount <= '0;
      vLine  <= '0;
      field  <= 1'b0;
    end else if (!enable) begin
      hCount <= '0;
      vLine  <= '0;
      field  <= 1'b0;
    end else if (atLineEnd) begin
      hCount <= '0;
      if (atFieldEnd) begin
        vLine <= '0;
        field <= interlace ? ~field : 1'b0;
      end else begin
        vLine <= vLine + CNT_W'(1);
      end
    end else begin
      hCount <= hCount + CNT_W'(1);
    end
  end

  always_comb begin
    strb.loadCfg   = !enable || atFrameEnd;
    strb.lineStart = enable && (hCount == '0);
  end
endmodule

// File: rtl/vtg_datapath.sv
module vtg_datapath
  import vtg_pkg::*;
#(
  parameter int CFG_W   = 32,
  parameter int DLY_LSB = 4,
  parameter int DLY_W   = 5,
  parameter int DLY_MAX = 30
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  vtgStrobe_t         strb,
  input  logic [CFG_W-1:0]   cfgSize,
  input  logic [CFG_W-1:0]   cfgHoriz,
  input  logic [CFG_W-1:0]   cfgVert,
  input  logic [CFG_W-1:0]   cfgSync,
  input  logic [CFG_W-1:0]   cfgCtrl,
  input  logic [CFG_W/2-1:0] hCount,
  input  logic [CFG_W/2-1:0] vLine,
  input  logic               field,
  output logic [CFG_W/2-1:0] hLast,
  output logic [CFG_W/2-1:0] vLast,
  output logic               interlace,
  output logic               hsync,
  output logic               vsync,
  output logic               de,
  output logic               blueFill,
  output logic               lineIrq
);
  localparam int HW = CFG_W / 2;
  localparam int NUM_WORDS = 5;
  localparam logic [CFG_W-1:0] CTRL_RST = CFG_W'(DLY_MAX) << DLY_LSB;
  typedef logic [HW+1:0] wide_t;

  logic [CFG_W-1:0] cfgIn [NUM_WORDS];
  logic [CFG_W-1:0] shw   [NUM_WORDS];

  assign cfgIn[0] = cfgSize;
  assign cfgIn[1] = cfgHoriz;
  assign cfgIn[2] = cfgVert;
  assign cfgIn[3] = cfgSync;
  assign cfgIn[4] = cfgCtrl;

  // One shadow register per configuration word, all loaded together
  for (genvar i = 0; i < NUM_WORDS; i++) begin : gShadow
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             shw[i] <= (i == NUM_WORDS - 1) ? CTRL_RST : '0;
      else if (strb.loadCfg) shw[i] <= cfgIn[i];
    end
  end

  logic [DLY_W-1:0] dlyRaw;
  logic             unusedCtrlBits;
  wide_t actW, actH, hbp, hsw, vbp, vsw, dly, vStart, irqLine, xw, yw;
  logic  hsyncAct, vsyncAct, hIn, vIn;

  always_comb begin
    actW    = wide_t'(shw[0][CFG_W-1:HW]) + wide_t'(1);
    actH    = wide_t'(shw[0][HW-1:0])     + wide_t'(1);
    hbp     = wide_t'(shw[1][HW-1:0])     + wide_t'(1);
    vbp     = wide_t'(shw[2][HW-1:0])     + wide_t'(1);
    hsw     = wide_t'(shw[3][CFG_W-1:HW]) + wide_t'(1);
    vsw     = wide_t'(shw[3][HW-1:0])     + wide_t'(1);
    dlyRaw  = shw[4][DLY_LSB +: DLY_W];
    dly     = (dlyRaw > DLY_W'(DLY_MAX)) ? wide_t'(DLY_MAX) : wide_t'(dlyRaw);
    vStart  = vbp + dly;
    irqLine = dly + wide_t'(2);
    xw      = wide_t'(hCount);
    yw      = wide_t'(vLine);
  end

  assign unusedCtrlBits = ^shw[4];
  assign hLast     = shw[1][CFG_W-1:HW];
  // lines in this field = (half-lines + field) / 2; odd totals favour field 1
  assign vLast     = HW'(((wide_t'(shw[2][CFG_W-1:HW]) + wide_t'(field)) >> 1) - wide_t'(1));
  assign interlace = shw[4][ILACE_BIT];

  assign hsyncAct = enable && (xw < hsw);
  assign vsyncAct = enable && (yw < vsw);
  assign hIn      = (xw >= hbp) && (xw < hbp + actW);
  assign vIn      = (yw >= vStart) && (yw < vStart + actH);

  assign hsync    = shw[4][HPOL_BIT] ? hsyncAct : ~hsyncAct;
  assign vsync    = shw[4][VPOL_BIT] ? vsyncAct : ~vsyncAct;
  assign de       = enable && hIn && vIn;
  assign blueFill = de && shw[4][BLUE_BIT];
  assign lineIrq  = strb.lineStart && (yw == irqLine);
endmodule

// File: rtl/video_timing_gen.sv
module video_timing_gen
  import vtg_pkg::*;
#(
  parameter int CFG_W   = 32,
  parameter int DLY_LSB = 4,
  parameter int DLY_W   = 5,
  parameter int DLY_MAX = 30
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [CFG_W-1:0]   cfgSize,
  input  logic [CFG_W-1:0]   cfgHoriz,
  input  logic [CFG_W-1:0]   cfgVert,
  input  logic [CFG_W-1:0]   cfgSync,
  input  logic [CFG_W-1:0]   cfgCtrl,
  output logic               hsync,
  output logic               vsync,
  output logic               de,
  output logic               blueFill,
  output logic [CFG_W/2-1:0] xPos,
  output logic [CFG_W/2-1:0] yPos,
  output logic               field,
  output logic               lineIrq
);
  localparam int CNT_W = CFG_W / 2;

  vtgStrobe_t       strb;
  logic [CNT_W-1:0] hLast, vLast;
  logic             interlace;

  vtg_control #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .hLast(hLast), .vLast(vLast), .interlace(interlace),
    .strb(strb), .hCount(xPos), .vLine(yPos), .field(field)
  );

  vtg_datapath #(
    .CFG_W(CFG_W), .DLY_LSB(DLY_LSB), .DLY_W(DLY_W), .DLY_MAX(DLY_MAX)
  ) uData (
    .clk(clk), .rstN(rstN), .enable(enable), .strb(strb),
    .cfgSize(cfgSize), .cfgHoriz(cfgHoriz), .cfgVert(cfgVert),
    .cfgSync(cfgSync), .cfgCtrl(cfgCtrl),
    .hCount(xPos), .vLine(yPos), .field(field),
    .hLast(hLast), .vLast(vLast), .interlace(interlace),
    .hsync(hsync), .vsync(vsync), .de(de), .blueFill(blueFill),
    .lineIrq(lineIrq)
  );
endmodule

// File: rtl/video_timing_gen_chk.sv
module video_timing_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             de,
  input logic             blueFill,
  input logic             lineIrq,
  input logic [CNT_W-1:0] xPos,
  input logic [CNT_W-1:0] yPos,
  input logic             field
);
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (!de && !lineIrq && !blueFill)); // R9

  AST_DISABLED_ORIGIN: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (xPos == '0 && yPos == '0 && !field)); // R9

  AST_PIXEL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> (xPos == '0 || xPos == $past(xPos) + CNT_W'(1))); // R2

  AST_FIELD_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(field) |-> (xPos == '0 && yPos == '0)); // R4

  AST_IRQ_LINE_START: assert property (@(posedge clk) disable iff (!rstN)
    lineIrq |-> (xPos == '0)); // R7

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    lineIrq |=> !lineIrq); // R7

  AST_BLUE_INSIDE: assert property (@(posedge clk) disable iff (!rstN)
    blueFill |-> de); // R8
endmodule

bind video_timing_gen video_timing_gen_chk #(.CNT_W(CFG_W / 2)) uChk (
  .clk(clk), .rstN(rstN), .enable(enable), .de(de), .blueFill(blueFill),
  .lineIrq(lineIrq), .xPos(xPos), .yPos(yPos), .field(field)
);

// File: tb/video_timing_gen_test.sv
module video_timing_gen_test;
  localparam time CLK_P = 20ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic en = 1'b0;
  logic [31:0] cfgSize, cfgHoriz, cfgVert, cfgSync, cfgCtrl;
  logic hsync, vsync, de, blueFill, field, lineIrq;
  logic [15:0] xPos, yPos;

  int tests = 0;
  int failed = 0;
  bit finished = 1'b0;

  // model geometry: current (applied) and pending (programmed)
  int cW, cH, cHt, cHbp, cHsw, cVh, cVbp, cVsw, cDly;
  bit cIl, cHp, cVp, cBl;
  int pW, pH, pHt, pHbp, pHsw, pVh, pVbp, pVsw, pDly;
  bit pIl, pHp, pVp, pBl;
  int mh = 0, mv = 0, mf = 0;

  always #(CLK_P / 2) clk = ~clk;

  video_timing_gen uut (
    .clk(clk), .rstN(rstN), .enable(en),
    .cfgSize(cfgSize), .cfgHoriz(cfgHoriz), .cfgVert(cfgVert),
    .cfgSync(cfgSync), .cfgCtrl(cfgCtrl),
    .hsync(hsync), .vsync(vsync), .de(de), .blueFill(blueFill),
    .xPos(xPos), .yPos(yPos), .field(field), .lineIrq(lineIrq)
  );

  task automatic setCfg(int w, int h, int ht, int hbp, int hsw, int vh, int vbp,
                        int vsw, bit il, bit hp, bit vp, int dlyField, bit bl);
    cfgSize  = {16'(w - 1), 16'(h - 1)};
    cfgHoriz = {16'(ht - 1), 16'(hbp - 1)};
    cfgVert  = {16'(vh), 16'(vbp - 1)};
    cfgSync  = {16'(hsw - 1), 16'(vsw - 1)};
    cfgCtrl  = {19'b0, bl, 3'b0, 5'(dlyField), 1'b0, vp, hp, il};
    pW = w; pH = h; pHt = ht; pHbp = hbp; pHsw = hsw; pVh = vh; pVbp = vbp;
    pVsw = vsw; pIl = il; pHp = hp; pVp = vp; pBl = bl;
    pDly = (dlyField > 30) ? 30 : dlyField;
  endtask

  task automatic applyPend();
    cW = pW; cH = pH; cHt = pHt; cHbp = pHbp; cHsw = pHsw; cVh = pVh; cVbp = pVbp;
    cVsw = pVsw; cIl = pIl; cHp = pHp; cVp = pVp; cBl = pBl; cDly = pDly;
  endtask

  task automatic checkNow(string tag);
    bit eDe, eHs, eVs, eIrq, eBl;
    logic [37:0] expV, gotV;
    eDe  = en && mh >= cHbp && mh < cHbp + cW && mv >= cVbp + cDly && mv < cVbp + cDly + cH;
    eHs  = (en && mh < cHsw) ? cHp : !cHp;
    eVs  = (en && mv < cVsw) ? cVp : !cVp;
    eIrq = en && mh == 0 && mv == cDly + 2;
    eBl  = eDe && cBl;
    expV = {eHs, eVs, eDe, eBl, eIrq, mf[0], 16'(mh), 16'(mv)};
    gotV = {hsync, vsync, de, blueFill, lineIrq, field, xPos, yPos};
    tests++;
    if (gotV !== expV) begin
      failed++;
      $display("FAIL %s: got hs/vs/de/bl/irq/f=%b x=%0d y=%0d, expected %b x=%0d y=%0d",
               tag, gotV[37:32], gotV[31:16], gotV[15:0], expV[37:32], mh, mv);
    end
  endtask

  task automatic checkInt(string tag, int got, int exp);
    tests++;
    if (got != exp) begin
      failed++;
      $display("FAIL %s: got %0d, expected %0d", tag, got, exp);
    end
  endtask

  task automatic stepModel();
    int lines;
    bit frameEnd;
    if (!en) begin
      mh = 0; mv = 0; mf = 0;
      applyPend();
    end else if (mh == cHt - 1) begin
      mh = 0;
      lines = (cVh + mf) / 2;
      if (mv == lines - 1) begin
        mv = 0;
        frameEnd = !cIl || (mf == 1);
        mf = cIl ? 1 - mf : 0;
        if (frameEnd) applyPend();
      end else begin
        mv++;
      end
    end else begin
      mh++;
    end
  endtask

  task automatic tick(string tag);
    @(negedge clk);
    stepModel();
    checkNow(tag);
  endtask

  task automatic startRun(string tag);
    tick(tag);
    en = 1'b1;
    #1;
    checkNow(tag);
  endtask

  task automatic stopRun(string tag);
    en = 1'b0;
    #1;
    checkNow(tag);
    tick(tag);
  endtask

  task automatic testReset();
    tick("R9 reset");
    checkInt("R9 reset xPos", int'(xPos), 0);
    checkInt("R9 reset vsync idle high", int'(vsync), 1);
  endtask

  task automatic testProgressive();
    int deCnt = 0, irqCnt = 0;
    setCfg(4, 3, 10, 3, 2, 16, 2, 1, 0, 1, 0, 1, 0);
    startRun("R2 R3 start");
    for (int i = 0; i < 160; i++) begin
      tick("R1 R2 R3 R7 progressive");
      if (i < 80) begin
        if (de) deCnt++;
        if (lineIrq) irqCnt++;
      end
    end
    checkInt("R1 de cycles per field", deCnt, 12);
    checkInt("R7 irq pulses per field", irqCnt, 1);
    stopRun("R9 stop");
  endtask

  task automatic testPolarity();
    setCfg(4, 3, 10, 3, 2, 16, 2, 2, 0, 0, 1, 1, 0);
    startRun("R5 start");
    for (int i = 0; i < 90; i++) tick("R5 polarity");
    stopRun("R5 R9 stop");
  endtask

  task automatic testInterlace();
    int f1Lines = 0;
    setCfg(4, 3, 10, 3, 2, 17, 2, 1, 1, 1, 1, 1, 0);
    startRun("R4 start");
    for (int i = 0; i < 360; i++) begin
      tick("R4 interlace");
      if (field && xPos == 16'd0 && i < 170) f1Lines++;
    end
    checkInt("R4 field 1 line count", f1Lines, 9);
    stopRun("R4 stop");
  endtask

  task automatic testDelayCap();
    int irqY = -1, deCnt = 0;
    setCfg(2, 3, 4, 1, 1, 80, 2, 1, 0, 1, 0, 31, 0);
    startRun("R6 start");
    for (int i = 0; i < 170; i++) begin
      tick("R6 R7 delay cap");
      if (lineIrq) irqY = int'(yPos);
      if (de && i < 160) deCnt++;
    end
    checkInt("R6 R7 irq line with capped delay", irqY, 32);
    checkInt("R6 de cycles", deCnt, 6);
    stopRun("R6 stop");
  endtask

  task automatic testBlue();
    int blCnt = 0;
    setCfg(4, 3, 10, 3, 2, 16, 2, 1, 0, 1, 0, 1, 1);
    startRun("R8 start");
    for (int i = 0; i < 80; i++) begin
      tick("R8 blue fill");
      if (blueFill) blCnt++;
    end
    checkInt("R8 blue cycles", blCnt, 12);
    stopRun("R8 stop");
  endtask

  task automatic testShadow();
    setCfg(4, 3, 10, 3, 2, 16, 2, 1, 0, 1, 0, 1, 0);
    startRun("R10 start");
    for (int i = 0; i < 25; i++) tick("R10 old frame");
    setCfg(6, 2, 12, 4, 3, 12, 1, 2, 0, 0, 1, 2, 0);
    for (int i = 0; i < 140; i++) tick("R10 deferred load");
    stopRun("R10 stop");
  endtask

  task automatic testDisableMid();
    setCfg(4, 3, 10, 3, 2, 16, 2, 1, 0, 1, 0, 1, 1);
    startRun("R9 start");
    for (int i = 0; i < 37; i++) tick("R9 run");
    stopRun("R9 mid-frame disable");
    checkInt("R9 yPos cleared", int'(yPos), 0);
    for (int i = 0; i < 5; i++) tick("R9 held");
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      failed++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    setCfg(4, 3, 10, 3, 2, 16, 2, 1, 0, 1, 0, 1, 0);
    applyPend();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testProgressive();
    testPolarity();
    testInterlace();
    testDelayCap();
    testBlue();
    testShadow();
    testDisableMid();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule